// File: doc/BRIEF.md
# Fault-Aware Spike Event Router

This block collects spike events from every neuron of one layer and places them, one at a time, on a single outgoing event channel. Each source neuron raises its bit of a parallel request vector. The router latches the bit as pending and chooses among pending sources in round-robin order. For the chosen source it walks a short list of synaptic connections. Each connection produces one output beat that carries the destination neuron address, the synaptic weight and the identity of the source that fired.

Next to the request vector the router reads an error-flag vector with one bit per source neuron. Whenever a beat is loaded for a source whose flag is set, the router replaces the weight with zero. A neuron that has been flagged as saturated can therefore keep firing without any effect on the next layer. The weight is zeroed, while the destination address of the beat is left as it is. All neurons of the layer share one instance of this recovery logic. The connection list of each source is held as a base index and a count into a shared synapse table. Both are written through a small configuration port.

Top module: `spike_router`

## Requirements
- R1: After reset, `out_valid` is 0. Every source count is 0, so a spike from any source produces no output beat until the source map has been written.
- R2: A served spike from source s produces cnt(s) beats in order k = 0..cnt(s)-1. Beat k carries the destination and weight of synapse entry (base(s)+k) mod TBL_DEPTH and `out_src` = s. `out_last` is 1 on the final beat only.
- R3: The weight of each beat loaded while `err_flag[s]` is 1 is zero, and the destination is unchanged.
- R4: The flag value is sampled when a beat is loaded into the output register. A flag change in the middle of a list does not alter the beat already presented, and it applies from the next beat onward.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_dest`, `out_weight`, `out_src` and `out_last` hold their values.
- R6: Pending sources are served in round-robin order. After a grant to source g, the search for the next grant starts at (g+1) mod N_SRC. The pointer starts at 0 after reset, and a grant to a source with count 0 also advances it.
- R7: A request is held pending until it is served, including when it arrives while another list is being emitted. Repeated requests from one source before it is served merge into a single event.
- R8: A source-map write (`cfg_kind`=0, `cfg_addr`=source) takes base = `cfg_wdata[TBL_AW-1:0]` and count = `cfg_wdata[TBL_AW+CNT_W:TBL_AW]`. A count above FANOUT is stored as FANOUT, and a source with count 0 emits nothing.
- R9: A synapse write (`cfg_kind`=1, `cfg_addr`=entry) takes weight = `cfg_wdata[WGT_W-1:0]` and destination = `cfg_wdata[WGT_W+DEST_W-1:WGT_W]`. A list that runs past entry TBL_DEPTH-1 continues at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spike_req | input | N_SRC | One spike-request bit per source neuron |
| err_flag | input | N_SRC | One error flag per source neuron; set means deliver with zero weight |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = source map entry, 1 = synapse table entry |
| cfg_addr | input | CFG_AW | Source index or synapse entry index |
| cfg_wdata | input | CFG_W | Packed write data (fields per R8/R9) |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_dest | output | DEST_W | Destination neuron address |
| out_weight | output | WGT_W | Synaptic weight, zero for flagged sources |
| out_src | output | SRC_W | Address of the source neuron that fired |
| out_last | output | 1 | Final beat of the source's list |

## Verification
The bench builds the router with N_SRC=5, FANOUT=3 and TBL_DEPTH=8. Because five sources is not a power of two, the round-robin pointer has to wrap through an explicit compare. The small table lets a list that starts at entry 7 cross back to entry 0. Setting FANOUT to 3 lets a written count of 5 exercise the clamp. A 3-bit pseudo-random ready pattern, together with held stalls, brings flag changes during a stalled list and requests that arrive while another list is being emitted into a few hundred cycles.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
  typedef enum logic {
    CFG_SRC_MAP = 1'b0,
    CFG_SYNAPSE = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/spkr_rr_arb.sv
module spkr_rr_arb #(
  parameter int N_SRC = 16,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_in,
  input  logic             take,
  output logic             gnt_fire,
  output logic [SRC_W-1:0] gnt_idx
);
  logic [N_SRC-1:0] pend_q;
  logic [SRC_W-1:0] ptr_q;
  logic             any_pend;
  logic [N_SRC-1:0] clr_mask;

  always_comb begin
    any_pend = 1'b0;
    gnt_idx  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      automatic int j = int'(ptr_q) + i;
      if (j >= N_SRC) j = j - N_SRC;
      if (!any_pend && pend_q[j]) begin
        any_pend = 1'b1;
        gnt_idx  = SRC_W'(j);
      end
    end
  end

  assign gnt_fire = any_pend && take;

  always_comb begin
    clr_mask = '0;
    if (gnt_fire) clr_mask[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ptr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | req_in;
      if (gnt_fire)
        ptr_q <= (int'(gnt_idx) == N_SRC-1) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/spkr_tables.sv
module spkr_tables
  import spkr_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int FANOUT    = 4,
  parameter int TBL_DEPTH = 32,
  parameter int DEST_W    = 8,
  parameter int WGT_W     = 8,
  localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int TBL_AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int CNT_W  = $clog2(FANOUT + 1),
  localparam int CFG_AW = (SRC_W > TBL_AW) ? SRC_W : TBL_AW,
  localparam int CFG_W  = (DEST_W + WGT_W > TBL_AW + CNT_W + 1) ? DEST_W + WGT_W : TBL_AW + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [SRC_W-1:0]  rd_src,
  output logic [TBL_AW-1:0] rd_base,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic [TBL_AW-1:0] rd_idx,
  output logic [DEST_W-1:0] rd_dest,
  output logic [WGT_W-1:0]  rd_wgt
);
  localparam logic [CFG_AW:0] SRC_LIM = (CFG_AW+1)'(N_SRC);
  localparam logic [CFG_AW:0] TBL_LIM = (CFG_AW+1)'(TBL_DEPTH);
  localparam logic [CNT_W:0]  FO_LIM  = (CNT_W+1)'(FANOUT);

  logic [TBL_AW-1:0] base_mem [N_SRC];
  logic [CNT_W-1:0]  cnt_mem  [N_SRC];
  logic [DEST_W-1:0] dest_mem [TBL_DEPTH];
  logic [WGT_W-1:0]  wgt_mem  [TBL_DEPTH];

  logic             src_wr, syn_wr;
  logic [CNT_W:0]   cnt_field;
  logic [CNT_W-1:0] cnt_clamped;

  assign src_wr      = cfg_we && (cfg_kind == CFG_SRC_MAP) && ({1'b0, cfg_addr} < SRC_LIM);
  assign syn_wr      = cfg_we && (cfg_kind == CFG_SYNAPSE) && ({1'b0, cfg_addr} < TBL_LIM);
  assign cnt_field   = cfg_wdata[TBL_AW +: CNT_W+1];
  assign cnt_clamped = (cnt_field > FO_LIM) ? FO_LIM[CNT_W-1:0] : cnt_field[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SRC; i++) cnt_mem[i] <= '0;
    end else if (src_wr) begin
      cnt_mem[cfg_addr[SRC_W-1:0]] <= cnt_clamped;
    end
  end

  always_ff @(posedge clk) begin
    if (src_wr) base_mem[cfg_addr[SRC_W-1:0]] <= cfg_wdata[TBL_AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (syn_wr) begin
      wgt_mem[cfg_addr[TBL_AW-1:0]]  <= cfg_wdata[WGT_W-1:0];
      dest_mem[cfg_addr[TBL_AW-1:0]] <= cfg_wdata[WGT_W +: DEST_W];
    end
  end

  assign rd_base = base_mem[rd_src];
  assign rd_cnt  = cnt_mem[rd_src];
  assign rd_dest = dest_mem[rd_idx];
  assign rd_wgt  = wgt_mem[rd_idx];
endmodule

// File: rtl/spkr_fanout.sv
module spkr_fanout #(
  parameter int N_SRC     = 16,
  parameter int FANOUT    = 4,
  parameter int TBL_DEPTH = 32,
  parameter int DEST_W    = 8,
  parameter int WGT_W     = 8,
  localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int TBL_AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int CNT_W  = $clog2(FANOUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt_fire,
  input  logic [SRC_W-1:0]  gnt_src,
  input  logic [TBL_AW-1:0] gnt_base,
  input  logic [CNT_W-1:0]  gnt_cnt,
  output logic              idle,
  output logic [TBL_AW-1:0] rd_idx,
  input  logic [DEST_W-1:0] rd_dest,
  input  logic [WGT_W-1:0]  rd_wgt,
  input  logic [N_SRC-1:0]  err_flag,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DEST_W-1:0] out_dest,
  output logic [WGT_W-1:0]  out_weight,
  output logic [SRC_W-1:0]  out_src,
  output logic              out_last
);
  logic              busy_q;
  logic [SRC_W-1:0]  src_q;
  logic [TBL_AW-1:0] idx_q;
  logic [CNT_W-1:0]  rem_q;
  logic              load;

  assign idle   = !busy_q;
  assign rd_idx = idx_q;
  assign load   = busy_q && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      src_q      <= '0;
      idx_q      <= '0;
      rem_q      <= '0;
      out_valid  <= 1'b0;
      out_dest   <= '0;
      out_weight <= '0;
      out_src    <= '0;
      out_last   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (load) begin
        out_valid  <= 1'b1;
        out_dest   <= rd_dest;
        out_weight <= err_flag[src_q] ? '0 : rd_wgt;
        out_src    <= src_q;
        out_last   <= (rem_q == CNT_W'(1));
        idx_q      <= (int'(idx_q) == TBL_DEPTH-1) ? '0 : idx_q + 1'b1;
        rem_q      <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) busy_q <= 1'b0;
      end
      if (gnt_fire && (gnt_cnt != '0)) begin
        busy_q <= 1'b1;
        src_q  <= gnt_src;
        idx_q  <= gnt_base;
        rem_q  <= gnt_cnt;
      end
    end
  end
endmodule

// File: rtl/spike_router.sv
module spike_router
  import spkr_pkg::*;
#(
  parameter int N_SRC     = 16,
  parameter int FANOUT    = 4,
  parameter int TBL_DEPTH = 32,
  parameter int DEST_W    = 8,
  parameter int WGT_W     = 8,
  localparam int SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int TBL_AW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1,
  localparam int CNT_W  = $clog2(FANOUT + 1),
  localparam int CFG_AW = (SRC_W > TBL_AW) ? SRC_W : TBL_AW,
  localparam int CFG_W  = (DEST_W + WGT_W > TBL_AW + CNT_W + 1) ? DEST_W + WGT_W : TBL_AW + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  spike_req,
  input  logic [N_SRC-1:0]  err_flag,
  input  logic              cfg_we,
  input  logic              cfg_kind,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DEST_W-1:0] out_dest,
  output logic [WGT_W-1:0]  out_weight,
  output logic [SRC_W-1:0]  out_src,
  output logic              out_last
);
  logic              take, gnt_fire;
  logic [SRC_W-1:0]  gnt_idx;
  logic [TBL_AW-1:0] map_base, rd_idx;
  logic [CNT_W-1:0]  map_cnt;
  logic [DEST_W-1:0] syn_dest;
  logic [WGT_W-1:0]  syn_wgt;

  spkr_rr_arb #(.N_SRC(N_SRC)) arb_i (
    .clk(clk), .rst(rst), .req_in(spike_req), .take(take),
    .gnt_fire(gnt_fire), .gnt_idx(gnt_idx)
  );

  spkr_tables #(
    .N_SRC(N_SRC), .FANOUT(FANOUT), .TBL_DEPTH(TBL_DEPTH),
    .DEST_W(DEST_W), .WGT_W(WGT_W)
  ) tbl_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_src(gnt_idx), .rd_base(map_base), .rd_cnt(map_cnt),
    .rd_idx(rd_idx), .rd_dest(syn_dest), .rd_wgt(syn_wgt)
  );

  spkr_fanout #(
    .N_SRC(N_SRC), .FANOUT(FANOUT), .TBL_DEPTH(TBL_DEPTH),
    .DEST_W(DEST_W), .WGT_W(WGT_W)
  ) fan_i (
    .clk(clk), .rst(rst), .gnt_fire(gnt_fire), .gnt_src(gnt_idx),
    .gnt_base(map_base), .gnt_cnt(map_cnt), .idle(take), .rd_idx(rd_idx),
    .rd_dest(syn_dest), .rd_wgt(syn_wgt), .err_flag(err_flag),
    .out_ready(out_ready), .out_valid(out_valid), .out_dest(out_dest),
    .out_weight(out_weight), .out_src(out_src), .out_last(out_last)
  );
endmodule

// File: rtl/spike_router_chk.sv
module spike_router_chk #(
  parameter int N_SRC  = 16,
  parameter int FANOUT = 4,
  parameter int DEST_W = 8,
  parameter int WGT_W  = 8,
  parameter int SRC_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SRC-1:0]  err_flag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DEST_W-1:0] out_dest,
  input logic [WGT_W-1:0]  out_weight,
  input logic [SRC_W-1:0]  out_src,
  input logic              out_last
);
  logic [N_SRC-1:0] flag_q;
  logic             prev_valid, prev_ready;
  int unsigned      beat_cnt;
  logic             new_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q     <= '0;
      prev_valid <= 1'b0;
      prev_ready <= 1'b0;
      beat_cnt   <= 0;
    end else begin
      flag_q     <= err_flag;
      prev_valid <= out_valid;
      prev_ready <= out_ready;
      if (out_valid && out_ready) beat_cnt <= out_last ? 0 : beat_cnt + 1;
    end
  end

  assign new_beat = out_valid && !(prev_valid && !prev_ready);

  // R1: reset clears the output
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  // R5: stalled beat holds
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dest) && $stable(out_weight)
                                   && $stable(out_src) && $stable(out_last)));

  // R3, R4: flag seen at load zeroes the weight
  a_r3_flag_zero: assert property (@(posedge clk) disable iff (rst)
    (new_beat && flag_q[out_src]) |-> (out_weight == '0));

  // R2: accepted non-final beat is followed at once by a beat of the same source
  a_r2_list_contig: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_src == $past(out_src)));

  // R8: a list never exceeds FANOUT beats
  a_r8_fanout_bound: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && beat_cnt == FANOUT-1) |-> out_last);
endmodule

bind spike_router spike_router_chk #(
  .N_SRC(N_SRC), .FANOUT(FANOUT), .DEST_W(DEST_W), .WGT_W(WGT_W), .SRC_W(SRC_W)
) chk_i (
  .clk(clk), .rst(rst), .err_flag(err_flag), .out_valid(out_valid),
  .out_ready(out_ready), .out_dest(out_dest), .out_weight(out_weight),
  .out_src(out_src), .out_last(out_last)
);

// File: tb/spike_router_tb_top.sv
module spike_router_tb_top;
  localparam int NS = 5, FO = 3, DEP = 8, DW = 6, WW = 8;
  localparam int SW = 3, TAW = 3, CNTW = 2, CFGAW = 3, CFGW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] spike_req = '0, err_flag = '0;
  logic cfg_we = 1'b0, cfg_kind = 1'b0;
  logic [CFGAW-1:0] cfg_addr = '0;
  logic [CFGW-1:0] cfg_wdata = '0;
  logic out_valid, out_ready, out_last;
  logic [DW-1:0] out_dest;
  logic [WW-1:0] out_weight;
  logic [SW-1:0] out_src;

  always #5 clk = ~clk;

  spike_router #(.N_SRC(NS), .FANOUT(FO), .TBL_DEPTH(DEP), .DEST_W(DW), .WGT_W(WW)) dut_i (
    .clk(clk), .rst(rst), .spike_req(spike_req), .err_flag(err_flag),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest),
    .out_weight(out_weight), .out_src(out_src), .out_last(out_last)
  );

  typedef struct { int src; int dest; int wgt; bit last; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  int rr_ptr = 0;
  int mbase[NS], mcnt[NS], mdest[DEP], mwgt[DEP];
  int rdy_mode = 0;
  logic [2:0] lfsr = 3'b101;
  bit done = 0;

  // ready driver: 0 = always, 1 = pseudo-random, 2 = held low
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[1:0], lfsr[2] ^ lfsr[1]};
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= lfsr[0];
      default: out_ready <= 1'b0;
    endcase
  end
  initial out_ready = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor
  logic pv = 0, pr = 0, pl = 0;
  logic [DW-1:0] pd = '0; logic [WW-1:0] pw = '0; logic [SW-1:0] ps = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pv && !pr) begin
        chk(out_valid === 1'b1 && out_dest === pd && out_weight === pw && out_src === ps && out_last === pl,
            "R5 stall hold", int'(out_weight), int'(pw));
      end
      if (out_valid === 1'b1 && out_ready === 1'b1) begin
        if (sb.size() == 0) begin
          chk(0, "R1/R8 unexpected beat", int'(out_src), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(out_src) == e.src, {e.tag, " src"}, int'(out_src), e.src);
          chk(int'(out_dest) == e.dest, {e.tag, " dest"}, int'(out_dest), e.dest);
          chk(int'(out_weight) == e.wgt, {e.tag, " weight"}, int'(out_weight), e.wgt);
          chk(out_last == e.last, {e.tag, " last"}, int'(out_last), int'(e.last));
        end
      end
    end
    pv = out_valid; pr = out_ready; pd = out_dest; pw = out_weight; ps = out_src; pl = out_last;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_src(input int s, input int base, input int cnt);
    @(posedge clk); #1;
    cfg_we = 1; cfg_kind = 0; cfg_addr = CFGAW'(s);
    cfg_wdata = '0;
    cfg_wdata[TAW-1:0] = TAW'(base);
    cfg_wdata[TAW +: CNTW+1] = (CNTW+1)'(cnt);
    mbase[s] = base; mcnt[s] = (cnt > FO) ? FO : cnt;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic cfg_syn(input int e, input int dest, input int wgt);
    @(posedge clk); #1;
    cfg_we = 1; cfg_kind = 1; cfg_addr = CFGAW'(e);
    cfg_wdata = '0;
    cfg_wdata[WW-1:0] = WW'(wgt);
    cfg_wdata[WW +: DW] = DW'(dest);
    mdest[e] = dest; mwgt[e] = wgt;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic push_src(input int s, input string tag);
    for (int k = 0; k < mcnt[s]; k++) begin
      exp_t e;
      int idx;
      idx = (mbase[s] + k) % DEP;
      e.src = s; e.dest = mdest[idx];
      e.wgt = err_flag[s] ? 0 : mwgt[idx];
      e.last = (k == mcnt[s] - 1); e.tag = tag;
      sb.push_back(e);
    end
  endtask

  // model of round-robin service for requests all pending together
  task automatic push_set(input logic [NS-1:0] mask, input string tag);
    int start;
    start = rr_ptr;
    for (int i = 0; i < NS; i++) begin
      int j;
      j = (start + i) % NS;
      if (mask[j]) begin
        push_src(j, tag);
        rr_ptr = (j + 1) % NS;
      end
    end
  endtask

  task automatic pulse(input logic [NS-1:0] mask);
    @(posedge clk); #1; spike_req = mask;
    @(posedge clk); #1; spike_req = '0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (sb.size() != 0 && guard < 2000) begin tick(1); guard++; end
    tick(12);
    chk(sb.size() == 0, "R2 all expected beats delivered", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mbase[i] = 0; mcnt[i] = 0; end
    tick(3); rst = 0;
    #3;
    chk(out_valid === 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R1: unprogrammed source emits nothing (count 0 after reset)
    push_set(5'b00001, "R1");
    pulse(5'b00001);
    drain();

    // program synapse table and source map
    for (int e = 0; e < DEP; e++) cfg_syn(e, 10 + e, 20 + 3 * e);
    cfg_src(0, 0, 3);
    cfg_src(1, 3, 1);
    cfg_src(2, 4, 0);   // R8 zero count
    cfg_src(3, 4, 5);   // R8 clamp to FANOUT
    cfg_src(4, 7, 2);   // R9 wrap 7 -> 0

    // R2 single sources one at a time
    push_set(5'b00001, "R2"); pulse(5'b00001); drain();
    push_set(5'b00010, "R2"); pulse(5'b00010); drain();
    push_set(5'b00100, "R8 zero"); pulse(5'b00100); drain();
    push_set(5'b01000, "R8 clamp"); pulse(5'b01000); drain();
    push_set(5'b10000, "R9 wrap"); pulse(5'b10000); drain();

    // R3 flagged source delivers zero weight
    @(posedge clk); #1; err_flag = 5'b00001;
    push_set(5'b00001, "R3"); pulse(5'b00001); drain();
    @(posedge clk); #1; err_flag = '0;

    // R6 simultaneous requests with random backpressure
    rdy_mode = 1;
    push_set(5'b11011, "R6"); pulse(5'b11011); drain();
    push_set(5'b11111, "R6"); pulse(5'b11111); drain();
    rdy_mode = 0;

    // R4 flag raised while a list is stalled
    rdy_mode = 2; tick(2);
    begin
      exp_t e;
      e.src = 0; e.dest = mdest[0]; e.wgt = mwgt[0]; e.last = 0; e.tag = "R4"; sb.push_back(e);
      e.dest = mdest[1]; e.wgt = 0; sb.push_back(e);
      e.dest = mdest[2]; e.last = 1; sb.push_back(e);
      rr_ptr = 1;
    end
    pulse(5'b00001);
    tick(6);
    chk(out_valid === 1'b1 && int'(out_weight) == mwgt[0], "R4 first beat presented", int'(out_weight), mwgt[0]);
    @(posedge clk); #1; err_flag = 5'b00001;
    tick(3);
    chk(int'(out_weight) == mwgt[0], "R4 presented beat unchanged", int'(out_weight), mwgt[0]);
    rdy_mode = 0;
    drain();
    @(posedge clk); #1; err_flag = '0;

    // R7 request arriving during service, repeated pulses merge
    rdy_mode = 2; tick(2);
    push_set(5'b01000, "R7");
    push_set(5'b00010, "R7");
    pulse(5'b01000);
    tick(4);
    pulse(5'b00010);
    tick(2);
    pulse(5'b00010);
    tick(3);
    rdy_mode = 1;
    drain();
    rdy_mode = 0;
    tick(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule